// File: doc/BRIEF.md
# ATA Task-File Register Channel

This block is the register front end of one ATA channel serving two drive slots. It decodes byte-wide host reads and writes to the command-block registers (error/features, sector count, sector number, cylinder low and high, drive/head, command/status) and to the control-block registers (device control, alternate address). The data register is not part of this block: a write at offset 0 is ignored and a read there returns 0.

It keeps a private copy of the four addressing registers for each drive. It handles soft reset through the device-control register, drive selection through the drive/head register, and the abort outcome of a command. It raises an interrupt request that the host can disable. Drive presence and type come in as static configuration. A command executor outside the block takes `cmd_strobe`, `cmd_code` and `features` and reports a rejected command on `abort_req`.

All host accesses are sampled on the rising clock edge. Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd`.

Top module: `ata_tf_channel`

## Requirements
- R1: After a synchronous reset the block holds these values: error 0x01, drive/head 0x00, status 0x00, command 0x00, device control 0x08 (bit 1 = interrupt disable, bit 2 = soft reset), features 0x00, irq 0. Each drive copy holds sector count 1, sector number 1 and cylinder 0x0000.
- R2: A device-control write (control block, offset 6) that takes bit 2 from 0 to 1 sets status to 0x90 and error to 0x01, and clears the command register. It also forces the stored interrupt-disable bit to 0, whatever value was written.
- R3: A device-control write that takes bit 2 from 1 to 0 clears status bit 7 (busy), sets status bit 6 (ready) and clears drive/head bits 3:0. For each drive it sets sector count and sector number to 1, and sets cylinder high:low to 0xEB14 for a packet device or to 0x0000 otherwise. A write that leaves bit 2 unchanged does none of this.
- R4: A write at offsets 2, 3, 4 or 5 (count, sector, cylinder low, cylinder high) updates the copy held for both drives. A read at those offsets returns the copy of the drive selected by drive/head bit 4.
- R5: A write at offset 6 stores the value ORed with 0xA0. Bit 4 of the stored value selects drive 1 when set and drive 0 when clear.
- R6: If a drive/head write selects an absent drive (type code 0), error bit 2 (abort) and status bit 0 (error) are set. All other bits are kept.
- R7: While an absent drive is selected, a read at command-block offset 6 returns 0xA0. A read at any other command-block offset, or at control-block offset 6, returns 0x00.
- R8: A read at control-block offset 7 always returns 0xFF. A command-block read at offset 1 returns the error register, while a write there sets the `features` output.
- R9: A pulse on `abort_req` sets status to 0x41 and error to 0x04 at the next edge, overriding any register update in the same cycle. If interrupts are enabled, it also raises irq.
- R10: irq is never 1 while the interrupt-disable bit is 1. Writing that bit to 1 drops a pending irq. A status read at command-block offset 7 clears irq, but a read at control-block offset 6 (alternate status) does not.
- R11: An access whose size code is not 0 (0 = byte, 1 = word, 2 = doubleword, 3 = reserved) changes no register. It pulses `size_err` for one cycle after the access.
- R12: A byte write at command-block offset 7 stores the value on `cmd_code` and pulses `cmd_strobe` high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_kind | input | 4 | Static drive types, [1:0] drive 0, [3:2] drive 1: 0 none, 1 disk, 2 packet device |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_ctrl | input | 1 | 1 selects the control block, 0 the command block |
| bus_addr | input | 3 | Register offset within the block |
| bus_size | input | 2 | Access size code, 0 = byte |
| bus_wdata | input | 8 | Write data |
| abort_req | input | 1 | Command-abort pulse from the command executor |
| bus_rdata | output | 8 | Registered read data |
| features | output | 8 | Last value written to the features register |
| cmd_code | output | 8 | Command register |
| cmd_strobe | output | 1 | One-cycle pulse after each command write |
| size_err | output | 1 | One-cycle pulse after an access whose size is not byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the soft-reset edge cases:
- A design that acted on the level of the reset bit would return the 0x90 status again on a repeated write of 0x04.
- A design that took the stored interrupt-disable bit from the written data would keep interrupts masked after a reset entry written with 0x06.
- A design that ignored the drive type in the reset exit would return 0x0000 for the packet drive, where 0xEB14 is expected.

It selects an absent drive and checks both the error/abort bits and the 0xA0/0x00 read-back. It also separates alternate-status reads, which must leave irq alone, from status reads, which must clear it. Random traffic with odd sizes checks that shadow copies stay per-drive on read yet shared on write, and that a non-byte write leaves every register unchanged.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam int N_DRIVES = 2;
  localparam int KIND_W   = 2;

  typedef enum logic [1:0] {
    DEV_NONE   = 2'd0,
    DEV_DISK   = 2'd1,
    DEV_PACKET = 2'd2
  } dev_kind_e;

  // command-block offsets
  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_ERRFT  = 3'd1;
  localparam logic [2:0] OFS_COUNT  = 3'd2;
  localparam logic [2:0] OFS_SECT   = 3'd3;
  localparam logic [2:0] OFS_CYLLO  = 3'd4;
  localparam logic [2:0] OFS_CYLHI  = 3'd5;
  localparam logic [2:0] OFS_DH     = 3'd6;
  localparam logic [2:0] OFS_CMDST  = 3'd7;
  // control-block offsets
  localparam logic [2:0] CB_DEVCTL  = 3'd6;
  localparam logic [2:0] CB_ALTADDR = 3'd7;

  localparam logic [1:0] SIZE_BYTE  = 2'd0;

  // fixed values
  localparam logic [7:0] ERR_POR      = 8'h01;
  localparam logic [7:0] DEVCTL_POR   = 8'h08;
  localparam logic [7:0] ST_SRST      = 8'h90;
  localparam logic [7:0] ST_ABORT     = 8'h41;
  localparam logic [7:0] ERR_ABORT    = 8'h04;
  localparam logic [7:0] DH_FORCE     = 8'hA0;
  localparam logic [7:0] ALT_ADDR_VAL = 8'hFF;
  localparam logic [7:0] SIG_PKT_HI   = 8'hEB;
  localparam logic [7:0] SIG_PKT_LO   = 8'h14;

  // device-control bit positions
  localparam int DC_NIEN = 1;
  localparam int DC_SRST = 2;
  localparam int DH_SEL  = 4;

  typedef struct packed {
    logic wr_feat;
    logic wr_count;
    logic wr_sect;
    logic wr_cyllo;
    logic wr_cylhi;
    logic wr_dh;
    logic wr_cmd;
    logic wr_devctl;
    logic rd_ok;
    logic rd_status;
  } tf_strobe_t;

  function automatic dev_kind_e kind_at(logic [N_DRIVES*KIND_W-1:0] kinds, logic sel);
    return dev_kind_e'(kinds[sel*KIND_W +: KIND_W]);
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
#(
  parameter int AW = 3,
  parameter int SW = 2
) (
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          ctrl_sel,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] size,
  output tf_strobe_t    stb,
  output logic          bad_size
);

  logic byte_ok;
  logic cw, bw;

  assign byte_ok  = (size == SW'(SIZE_BYTE));
  assign bad_size = (wr_en | rd_en) & ~byte_ok;
  assign cw       = wr_en & byte_ok & ~ctrl_sel;
  assign bw       = wr_en & byte_ok &  ctrl_sel;

  always_comb begin
    stb           = '0;
    stb.wr_feat   = cw & (addr == AW'(OFS_ERRFT));
    stb.wr_count  = cw & (addr == AW'(OFS_COUNT));
    stb.wr_sect   = cw & (addr == AW'(OFS_SECT));
    stb.wr_cyllo  = cw & (addr == AW'(OFS_CYLLO));
    stb.wr_cylhi  = cw & (addr == AW'(OFS_CYLHI));
    stb.wr_dh     = cw & (addr == AW'(OFS_DH));
    stb.wr_cmd    = cw & (addr == AW'(OFS_CMDST));
    stb.wr_devctl = bw & (addr == AW'(CB_DEVCTL));
    stb.rd_ok     = rd_en & byte_ok;
    stb.rd_status = rd_en & byte_ok & ~ctrl_sel & (addr == AW'(OFS_CMDST));
  end

endmodule

// File: rtl/ata_tf_shadow.sv
module ata_tf_shadow
  import ata_tf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_count,
  input  logic                          wr_sect,
  input  logic                          wr_cyllo,
  input  logic                          wr_cylhi,
  input  logic [DW-1:0]                 wdata,
  input  logic                          srst_exit,
  input  logic [N_DRIVES*KIND_W-1:0]    kinds,
  input  logic                          sel,
  output logic [DW-1:0]                 count_o,
  output logic [DW-1:0]                 sect_o,
  output logic [DW-1:0]                 cyllo_o,
  output logic [DW-1:0]                 cylhi_o
);

  logic [DW-1:0] cnt_q   [N_DRIVES];
  logic [DW-1:0] sect_q  [N_DRIVES];
  logic [DW-1:0] cyllo_q [N_DRIVES];
  logic [DW-1:0] cylhi_q [N_DRIVES];

  for (genvar g = 0; g < N_DRIVES; g++) begin : g_drv
    dev_kind_e kd;
    assign kd = dev_kind_e'(kinds[g*KIND_W +: KIND_W]);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g]   <= DW'(1);
        sect_q[g]  <= DW'(1);
        cyllo_q[g] <= '0;
        cylhi_q[g] <= '0;
      end else if (srst_exit) begin
        cnt_q[g]   <= DW'(1);
        sect_q[g]  <= DW'(1);
        cyllo_q[g] <= (kd == DEV_PACKET) ? DW'(SIG_PKT_LO) : '0;
        cylhi_q[g] <= (kd == DEV_PACKET) ? DW'(SIG_PKT_HI) : '0;
      end else begin
        if (wr_count) cnt_q[g]   <= wdata;
        if (wr_sect)  sect_q[g]  <= wdata;
        if (wr_cyllo) cyllo_q[g] <= wdata;
        if (wr_cylhi) cylhi_q[g] <= wdata;
      end
    end
  end

  assign count_o = cnt_q[sel];
  assign sect_o  = sect_q[sel];
  assign cyllo_o = cyllo_q[sel];
  assign cylhi_o = cylhi_q[sel];

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  tf_strobe_t                 stb,
  input  logic [DW-1:0]              wdata,
  input  logic                       abort_req,
  input  logic [N_DRIVES*KIND_W-1:0] kinds,
  output logic [DW-1:0]              status_q,
  output logic [DW-1:0]              error_q,
  output logic [DW-1:0]              dh_q,
  output logic [DW-1:0]              cmd_q,
  output logic [DW-1:0]              devctl_q,
  output logic [DW-1:0]              feat_q,
  output logic                       irq_q,
  output logic                       srst_exit
);

  logic srst_enter;
  logic nien_next;
  logic new_absent;

  assign srst_enter = stb.wr_devctl &  wdata[DC_SRST] & ~devctl_q[DC_SRST];
  assign srst_exit  = stb.wr_devctl & ~wdata[DC_SRST] &  devctl_q[DC_SRST];
  assign nien_next  = stb.wr_devctl ? (wdata[DC_NIEN] & ~srst_enter) : devctl_q[DC_NIEN];
  assign new_absent = (kind_at(kinds, wdata[DH_SEL]) == DEV_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      error_q  <= DW'(ERR_POR);
      dh_q     <= '0;
      cmd_q    <= '0;
      devctl_q <= DW'(DEVCTL_POR);
      feat_q   <= '0;
    end else begin
      if (stb.wr_devctl) begin
        devctl_q          <= wdata;
        devctl_q[DC_NIEN] <= nien_next;
      end
      if (stb.wr_feat) feat_q <= wdata;
      if (stb.wr_cmd)  cmd_q  <= wdata;
      if (stb.wr_dh) begin
        dh_q <= wdata | DW'(DH_FORCE);
        if (new_absent) begin
          error_q[2]  <= 1'b1;
          status_q[0] <= 1'b1;
        end
      end
      if (srst_enter) begin
        status_q <= DW'(ST_SRST);
        error_q  <= DW'(ERR_POR);
        cmd_q    <= '0;
      end
      if (srst_exit) begin
        status_q[7]   <= 1'b0;
        status_q[6]   <= 1'b1;
        dh_q[3:0]     <= 4'h0;
      end
      if (abort_req) begin
        status_q <= DW'(ST_ABORT);
        error_q  <= DW'(ERR_ABORT);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                irq_q <= 1'b0;
    else if (nien_next)     irq_q <= 1'b0;
    else if (abort_req)     irq_q <= 1'b1;
    else if (stb.rd_status) irq_q <= 1'b0;
  end

endmodule

// File: rtl/ata_tf_channel.sv
module ata_tf_channel
  import ata_tf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int SW = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_DRIVES*KIND_W-1:0] drv_kind,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic                       bus_ctrl,
  input  logic [AW-1:0]              bus_addr,
  input  logic [SW-1:0]              bus_size,
  input  logic [DW-1:0]              bus_wdata,
  input  logic                       abort_req,
  output logic [DW-1:0]              bus_rdata,
  output logic [DW-1:0]              features,
  output logic [DW-1:0]              cmd_code,
  output logic                       cmd_strobe,
  output logic                       size_err,
  output logic                       irq
);

  tf_strobe_t    stb;
  logic          bad_size;
  logic          srst_exit;
  logic [DW-1:0] status_w, error_w, dh_w, devctl_w;
  logic [DW-1:0] cnt_w, sect_w, cyllo_w, cylhi_w;
  logic [DW-1:0] rd_next;
  logic          cur_absent;

  ata_tf_decode #(.AW(AW), .SW(SW)) u_dec (
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .ctrl_sel (bus_ctrl),
    .addr     (bus_addr),
    .size     (bus_size),
    .stb      (stb),
    .bad_size (bad_size)
  );

  ata_tf_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .wdata     (bus_wdata),
    .abort_req (abort_req),
    .kinds     (drv_kind),
    .status_q  (status_w),
    .error_q   (error_w),
    .dh_q      (dh_w),
    .cmd_q     (cmd_code),
    .devctl_q  (devctl_w),
    .feat_q    (features),
    .irq_q     (irq),
    .srst_exit (srst_exit)
  );

  ata_tf_shadow #(.DW(DW)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .wr_count  (stb.wr_count),
    .wr_sect   (stb.wr_sect),
    .wr_cyllo  (stb.wr_cyllo),
    .wr_cylhi  (stb.wr_cylhi),
    .wdata     (bus_wdata),
    .srst_exit (srst_exit),
    .kinds     (drv_kind),
    .sel       (dh_w[DH_SEL]),
    .count_o   (cnt_w),
    .sect_o    (sect_w),
    .cyllo_o   (cyllo_w),
    .cylhi_o   (cylhi_w)
  );

  assign cur_absent = (kind_at(drv_kind, dh_w[DH_SEL]) == DEV_NONE);

  always_comb begin
    rd_next = '0;
    if (bus_ctrl) begin
      if (bus_addr == AW'(CB_ALTADDR))                   rd_next = DW'(ALT_ADDR_VAL);
      else if (bus_addr == AW'(CB_DEVCTL) && !cur_absent) rd_next = status_w;
    end else if (cur_absent) begin
      if (bus_addr == AW'(OFS_DH)) rd_next = DW'(DH_FORCE);
    end else begin
      unique case (bus_addr)
        AW'(OFS_ERRFT): rd_next = error_w;
        AW'(OFS_COUNT): rd_next = cnt_w;
        AW'(OFS_SECT):  rd_next = sect_w;
        AW'(OFS_CYLLO): rd_next = cyllo_w;
        AW'(OFS_CYLHI): rd_next = cylhi_w;
        AW'(OFS_DH):    rd_next = dh_w;
        AW'(OFS_CMDST): rd_next = status_w;
        default:        rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      cmd_strobe <= 1'b0;
      size_err   <= 1'b0;
    end else begin
      cmd_strobe <= stb.wr_cmd;
      size_err   <= bad_size;
      if (stb.rd_ok)   bus_rdata <= rd_next;
      else if (bus_rd) bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/ata_tf_channel_chk.sv
module ata_tf_channel_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_ctrl,
  input logic [2:0] bus_addr,
  input logic [1:0] bus_size,
  input logic [7:0] bus_wdata,
  input logic       abort_req,
  input logic       irq,
  input logic       cmd_strobe,
  input logic [7:0] cmd_code,
  input logic       size_err,
  input logic [7:0] status_w,
  input logic [7:0] error_w,
  input logic [7:0] dh_w,
  input logic [7:0] devctl_w
);

  AST_SRST_ENTER: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_ctrl && bus_addr == 3'd6 && bus_size == 2'd0 && bus_wdata[2] && !devctl_w[2] && !abort_req)
    |=> (status_w == 8'h90 && error_w == 8'h01 && !devctl_w[1])); // R2

  AST_DH_FORCED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ctrl && bus_addr == 3'd6 && bus_size == 2'd0) |=> (dh_w[7] && dh_w[5])); // R5

  AST_ABORT_VALUES: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (status_w == 8'h41 && error_w == 8'h04)); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> !devctl_w[1]); // R10

  AST_SIZE_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_size != 2'd0) |=> size_err); // R11

  AST_SIZE_NO_DH: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_size != 2'd0) |=> $stable(dh_w)); // R11

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_ctrl && bus_addr == 3'd7 && bus_size == 2'd0)
    |=> (cmd_strobe && cmd_code == $past(bus_wdata))); // R12

endmodule

bind ata_tf_channel ata_tf_channel_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_ctrl   (bus_ctrl),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_wdata  (bus_wdata),
  .abort_req  (abort_req),
  .irq        (irq),
  .cmd_strobe (cmd_strobe),
  .cmd_code   (cmd_code),
  .size_err   (size_err),
  .status_w   (status_w),
  .error_w    (error_w),
  .dh_w       (dh_w),
  .devctl_w   (devctl_w)
);

// File: tb/ata_tf_channel_bench.sv
module ata_tf_channel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] drv_kind = 4'b1001;
  logic       bus_wr = 0, bus_rd = 0, bus_ctrl = 0, abort_req = 0;
  logic [2:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, features, cmd_code;
  logic       cmd_strobe, size_err, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_tf_channel u_ata_tf_channel (
    .clk(clk), .rst(rst), .drv_kind(drv_kind), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_ctrl(bus_ctrl), .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .abort_req(abort_req), .bus_rdata(bus_rdata), .features(features), .cmd_code(cmd_code),
    .cmd_strobe(cmd_strobe), .size_err(size_err), .irq(irq)
  );

  // reference state
  logic [7:0] m_err, m_st, m_dh, m_cmd, m_ctl;
  logic       m_irq;
  logic [7:0] m_cnt [2];
  logic [7:0] m_sec [2];
  logic [7:0] m_lo  [2];
  logic [7:0] m_hi  [2];

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_of(logic s);
    return s ? drv_kind[3:2] : drv_kind[1:0];
  endfunction

  task automatic m_por();
    m_err = 8'h01; m_st = 8'h00; m_dh = 8'h00; m_cmd = 8'h00; m_ctl = 8'h08; m_irq = 0;
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 1; m_sec[i] = 1; m_lo[i] = 0; m_hi[i] = 0;
    end
  endtask

  function automatic logic [7:0] exp_read(logic cs, logic [2:0] a);
    logic s;
    logic absent;
    s = m_dh[4];
    absent = (kind_of(s) == 2'd0);
    if (cs) begin
      if (a == 3'd7) return 8'hFF;
      if (a == 3'd6) return absent ? 8'h00 : m_st;
      return 8'h00;
    end
    if (absent) return (a == 3'd6) ? 8'hA0 : 8'h00;
    case (a)
      3'd1: return m_err;
      3'd2: return m_cnt[s];
      3'd3: return m_sec[s];
      3'd4: return m_lo[s];
      3'd5: return m_hi[s];
      3'd6: return m_dh;
      3'd7: return m_st;
      default: return 8'h00;
    endcase
  endfunction

  task automatic hw_reset(logic [3:0] kinds);
    @(negedge clk);
    rst = 1; drv_kind = kinds;
    repeat (2) @(negedge clk);
    rst = 0;
    m_por();
  endtask

  task automatic bus_write(logic cs, logic [2:0] a, logic [7:0] d, logic [1:0] sz);
    @(negedge clk);
    bus_wr = 1; bus_ctrl = cs; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_wr = 0;
    if (sz != 0) begin
      chk("R11 size_err", {15'd0, size_err}, 16'd1);
      return;
    end
    if (cs) begin
      if (a == 3'd6) begin
        logic rise, fall;
        rise = d[2] && !m_ctl[2];
        fall = !d[2] && m_ctl[2];
        m_ctl = d;
        if (rise) begin
          m_ctl[1] = 0; m_st = 8'h90; m_err = 8'h01; m_cmd = 8'h00;
        end
        if (fall) begin
          m_st[7] = 0; m_st[6] = 1; m_dh[3:0] = 0;
          for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 1; m_sec[i] = 1;
            m_lo[i] = (kind_of(i[0]) == 2'd2) ? 8'h14 : 8'h00;
            m_hi[i] = (kind_of(i[0]) == 2'd2) ? 8'hEB : 8'h00;
          end
        end
        if (m_ctl[1]) m_irq = 0;
      end
    end else begin
      case (a)
        3'd2: begin m_cnt[0] = d; m_cnt[1] = d; end
        3'd3: begin m_sec[0] = d; m_sec[1] = d; end
        3'd4: begin m_lo[0] = d;  m_lo[1] = d;  end
        3'd5: begin m_hi[0] = d;  m_hi[1] = d;  end
        3'd6: begin
          m_dh = d | 8'hA0;
          if (kind_of(d[4]) == 2'd0) begin m_err[2] = 1; m_st[0] = 1; end
        end
        3'd7: begin
          m_cmd = d;
          chk("R12 strobe", {15'd0, cmd_strobe}, 16'd1);
          chk("R12 code", {8'd0, cmd_code}, {8'd0, d});
        end
        default: ;
      endcase
    end
  endtask

  task automatic bus_read(logic cs, logic [2:0] a, logic [1:0] sz, string req);
    logic [7:0] e;
    e = (sz == 0) ? exp_read(cs, a) : 8'h00;
    @(negedge clk);
    bus_rd = 1; bus_ctrl = cs; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_rd = 0;
    chk(req, {8'd0, bus_rdata}, {8'd0, e});
    if (sz != 0) chk("R11 size_err", {15'd0, size_err}, 16'd1);
    else if (!cs && a == 3'd7) m_irq = 0;
  endtask

  task automatic do_abort();
    @(negedge clk);
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
    m_st = 8'h41; m_err = 8'h04;
    if (!m_ctl[1]) m_irq = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_por();
    hw_reset(4'b1001);   // drive 0 disk, drive 1 packet

    // R1 power-on values
    bus_read(0, 3'd1, 0, "R1 error");
    chk("R1 error lit", {8'd0, bus_rdata}, 16'h0001);
    bus_read(0, 3'd6, 0, "R1 drive/head");
    chk("R1 dh lit", {8'd0, bus_rdata}, 16'h0000);
    bus_read(0, 3'd7, 0, "R1 status");
    bus_read(0, 3'd2, 0, "R1 count");
    chk("R1 count lit", {8'd0, bus_rdata}, 16'h0001);
    bus_read(0, 3'd4, 0, "R1 cyl lo");
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 features", {8'd0, features}, 16'd0);

    // R8 alternate address and features/error split
    bus_read(1, 3'd7, 0, "R8 alt addr");
    chk("R8 alt lit", {8'd0, bus_rdata}, 16'h00FF);
    bus_write(0, 3'd1, 8'h5A, 0);
    chk("R8 features out", {8'd0, features}, 16'h005A);
    bus_read(0, 3'd1, 0, "R8 error at features");

    // R4 R5 shared writes, per-drive reads
    bus_write(0, 3'd2, 8'h33, 0);
    bus_write(0, 3'd5, 8'hC7, 0);
    bus_write(0, 3'd6, 8'h13, 0);
    bus_read(0, 3'd6, 0, "R5 dh forced");
    chk("R5 dh lit", {8'd0, bus_rdata}, 16'h00B3);
    bus_read(0, 3'd2, 0, "R4 count drive1");
    chk("R4 count lit", {8'd0, bus_rdata}, 16'h0033);
    bus_read(0, 3'd5, 0, "R4 cylhi drive1");

    // R2 R3 soft reset edges, packet signature on drive 1
    bus_write(1, 3'd6, 8'h04, 0);
    bus_read(0, 3'd7, 0, "R2 status");
    chk("R2 status lit", {8'd0, bus_rdata}, 16'h0090);
    chk("R2 cmd cleared", {8'd0, cmd_code}, 16'h0000);
    bus_write(0, 3'd7, 8'h77, 0);
    bus_write(1, 3'd6, 8'h04, 0);   // no edge
    chk("R3 no edge keeps cmd", {8'd0, cmd_code}, 16'h0077);
    bus_write(1, 3'd6, 8'h00, 0);
    bus_read(0, 3'd7, 0, "R3 status");
    chk("R3 status lit", {8'd0, bus_rdata}, 16'h0050);
    bus_read(0, 3'd6, 0, "R3 head cleared");
    chk("R3 dh lit", {8'd0, bus_rdata}, 16'h00B0);
    bus_read(0, 3'd5, 0, "R3 packet cyl hi");
    chk("R3 EB lit", {8'd0, bus_rdata}, 16'h00EB);
    bus_read(0, 3'd4, 0, "R3 packet cyl lo");
    chk("R3 14 lit", {8'd0, bus_rdata}, 16'h0014);
    bus_write(0, 3'd6, 8'h00, 0);
    bus_read(0, 3'd5, 0, "R3 disk cyl hi");
    chk("R3 disk lit", {8'd0, bus_rdata}, 16'h0000);
    bus_read(0, 3'd2, 0, "R3 count one");

    // R9 R10 abort and interrupt
    do_abort();
    chk("R9 irq", {15'd0, irq}, 16'd1);
    bus_read(0, 3'd1, 0, "R9 error");
    chk("R9 error lit", {8'd0, bus_rdata}, 16'h0004);
    bus_read(1, 3'd6, 0, "R10 alt status");
    chk("R10 alt keeps irq", {15'd0, irq}, 16'd1);
    bus_read(0, 3'd7, 0, "R9 status");
    chk("R9 status lit", {8'd0, bus_rdata}, 16'h0041);
    chk("R10 status read clears", {15'd0, irq}, 16'd0);
    do_abort();
    bus_write(1, 3'd6, 8'h02, 0);
    chk("R10 disable drops irq", {15'd0, irq}, 16'd0);
    do_abort();
    chk("R10 masked abort", {15'd0, irq}, 16'd0);
    bus_write(1, 3'd6, 8'h06, 0);   // reset entry forces enable
    do_abort();
    chk("R2 enable forced", {15'd0, irq}, 16'd1);
    bus_write(1, 3'd6, 8'h00, 0);
    bus_read(0, 3'd7, 0, "R10 clear");

    // R12 command
    bus_write(0, 3'd7, 8'hEC, 0);
    @(negedge clk);
    chk("R12 single pulse", {15'd0, cmd_strobe}, 16'd0);

    // R11 bad size leaves state
    bus_write(0, 3'd6, 8'h10, 2'd1);
    bus_read(0, 3'd6, 0, "R11 dh unchanged");
    bus_write(0, 3'd2, 8'h99, 2'd2);
    bus_read(0, 3'd2, 0, "R11 count unchanged");
    bus_read(0, 3'd7, 2'd3, "R11 read zero");

    // R6 R7 absent drive
    hw_reset(4'b0010);   // drive 0 packet, drive 1 absent
    bus_write(0, 3'd6, 8'h10, 0);
    bus_read(0, 3'd6, 0, "R7 dh absent");
    chk("R7 A0 lit", {8'd0, bus_rdata}, 16'h00A0);
    bus_read(0, 3'd2, 0, "R7 count absent");
    bus_read(0, 3'd7, 0, "R7 status absent");
    bus_read(1, 3'd6, 0, "R7 alt status absent");
    bus_read(1, 3'd7, 0, "R8 alt addr absent");
    bus_write(0, 3'd6, 8'h00, 0);
    bus_read(0, 3'd1, 0, "R6 abort bit");
    chk("R6 err lit", {8'd0, bus_rdata}, 16'h0005);
    bus_read(0, 3'd7, 0, "R6 error bit");
    chk("R6 st lit", {8'd0, bus_rdata}, 16'h0001);

    // random traffic
    hw_reset(4'b0110);   // drive 0 packet, drive 1 disk
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [1:0] sz;
      logic [2:0] a;
      logic cs;
      op = $urandom % 10;
      sz = (($urandom % 8) == 0) ? 2'(1 + $urandom % 3) : 2'd0;
      a  = 3'($urandom);
      cs = (($urandom % 4) == 0);
      if (op == 0)      do_abort();
      else if (op < 5)  bus_write(cs, a, 8'($urandom), sz);
      else              bus_read(cs, a, sz, "R4 random read");
      chk("R10 random irq", {15'd0, irq}, {15'd0, m_irq});
    end

    finish_run();
  end

endmodule